// File: doc/BRIEF.md
# Channel Status Block Decoder

This block sits behind a digital audio receiver that has already recovered frames and preambles. It takes one channel status bit per frame and a marker that flags the first frame of each 192-frame block. It keeps the header bits the outputs need, runs a serial CRC over the block and holds the received check byte. When the next block starts, it loads a new set of decoded status flags and a consumer/professional indicator in a single clock, and pulses a one-cycle block strobe.

The five status flags have no fixed meaning. Which meaning applies depends on bit 0 of byte 0 of the block. In consumer use they report audio or data, copy permission, pre-emphasis, original or copy, and whether the category code is one of the "ignorant" ones. In professional use they report audio or data, a two-bit emphasis code, channel mode bit 9, and whether the block CRC matched. Bit n of byte k is the bit received in frame 8k+n of a block, counting from 0 at the flagged frame.

Top module: `cs_block_decoder`

## Requirements
- R1: After reset, consumer_mode = 1, status_flags = 5'b01110 and block_strobe = 0. This is the decode of an all-zero consumer block.
- R2: A block counts as complete when exactly 192 valid frames have been received, starting with a flagged frame, and the next flagged frame then arrives. On the clock edge that samples that next flagged frame, consumer_mode and status_flags load their new values together and block_strobe goes high for exactly one cycle. The outputs do not change at any other time.
- R3: A flagged frame that arrives after fewer than or more than 192 frames of the current block discards that block. No strobe is issued for it and the outputs keep their previous values. A flagged frame that arrives before any block has started also produces no strobe.
- R4: consumer_mode is the inverse of byte 0 bit 0. 1 means consumer and 0 means professional.
- R5: status_flags[0] equals byte 0 bit 1 in both modes. 0 means audio and 1 means non-audio.
- R6: In consumer mode, status_flags[1] is the inverse of byte 0 bit 2, so 0 means copy permitted. status_flags[2] is the inverse of byte 0 bit 3, so 0 means pre-emphasis is present.
- R7: In consumer mode, status_flags[3] is 0 for original and 1 for copy. The category code is byte 1 bits 0 to 6, with bit 0 first. If that code starts with 0,0,1 or 0,1,1,1 or 1,0,0, status_flags[3] equals byte 1 bit 7. Otherwise it is the inverse of byte 1 bit 7.
- R8: In consumer mode, status_flags[4] is 0 when the category code is all zeros, or when only bits 1 and 2 of the code are set. It is 1 for every other code.
- R9: In professional mode, {status_flags[2], status_flags[1]} encodes byte 0 bits 2,3,4, listed in that order. 000 gives 11, 100 gives 10, 110 gives 01 and 111 gives 00. Any other combination gives 11.
- R10: In professional mode, status_flags[3] is the inverse of byte 1 bit 1.
- R11: In professional mode, status_flags[4] is 1 when a CRC over frames 0 to 183 equals byte 23 and 0 otherwise. The CRC is 8 bits with polynomial x^8+x^4+x^3+x^2+1 and an all-ones start value. Bits are fed in frame order, and each new bit is XORed into the register MSB before the shift. Byte 23 has bit n taken from frame 184+n.
- R12: Cycles with frame_valid low are ignored. They never advance the frame count, never alter captured bits and never produce a strobe, so idle gaps between frames leave the decode unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| frame_valid | input | 1 | A frame's channel status bit is present this cycle |
| frame_first | input | 1 | This frame is frame 0 of a block (only meaningful with frame_valid) |
| cs_bit | input | 1 | Channel status bit of the frame |
| consumer_mode | output | 1 | 1 = consumer interpretation, 0 = professional |
| status_flags | output | 5 | Decoded status flags, meaning per mode (R5 to R11) |
| block_strobe | output | 1 | One-cycle pulse when new status is loaded |

## Verification
The bench sends blocks whose category codes sit on each inversion pattern, with the generation bit at both values, as well as the two ignorant codes and their near neighbours. A design that decodes the code bits in reverse order would flip status_flags[3] or [4] on these blocks. Professional blocks cover every emphasis code, including a reserved one, along with good and corrupted check bytes. A wrong bit order or a wrong start value in the CRC would clear the match flag on good blocks. The bench also sends short blocks, over-long blocks and blocks with idle gaps between frames. A design that commits on any flagged frame, or that counts idle cycles, would produce extra strobes or output changes, and the bench compares those against its model on every clock.

// File: rtl/cs_dec_pkg.sv
package cs_dec_pkg;

  localparam int CS_FRAMES   = 192;
  localparam int CS_CRC_W    = 8;
  localparam int CS_FLAG_W   = 5;

  // header fields that feed the decode (byte 0 bits 0..4, all of byte 1)
  localparam int CS_B0_BASE  = 0;
  localparam int CS_B0_W     = 5;
  localparam int CS_B1_BASE  = 8;
  localparam int CS_B1_W     = 8;

  localparam logic [CS_CRC_W-1:0] CS_CRC_POLY = 8'h1D;
  localparam logic [CS_CRC_W-1:0] CS_CRC_INIT = 8'hFF;

  // flag positions
  localparam int FLG_DATA = 0;
  localparam int FLG_LO   = 1;
  localparam int FLG_HI   = 2;
  localparam int FLG_GEN  = 3;
  localparam int FLG_CAT  = 4;

  typedef struct packed {
    logic                 consumer;
    logic [CS_FLAG_W-1:0] flags;
  } cs_status_t;

  localparam cs_status_t CS_STATUS_RST = '{consumer: 1'b1, flags: 5'b01110};

endpackage

// File: rtl/cs_frame_counter.sv
module cs_frame_counter #(
  parameter int FRAMES = 192,
  localparam int IDX_W = $clog2(FRAMES + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_valid,
  input  logic             frame_first,
  output logic [IDX_W-1:0] bit_idx,
  output logic             commit
);

  localparam logic [IDX_W-1:0] FULL = IDX_W'(FRAMES);
  localparam logic [IDX_W-1:0] OVER = IDX_W'(FRAMES + 1);

  logic [IDX_W-1:0] cnt_q, cnt_d;

  // index of the bit presented this cycle; flagged frame restarts at zero
  assign bit_idx = frame_first ? '0 : cnt_q;
  assign commit  = frame_valid & frame_first & (cnt_q == FULL);

  always_comb begin
    cnt_d = cnt_q;
    if (frame_valid) begin
      if (frame_first)       cnt_d = IDX_W'(1);
      else if (cnt_q != OVER) cnt_d = cnt_q + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/cs_bit_window.sv
module cs_bit_window #(
  parameter int IDX_W = 8,
  parameter int BASE  = 0,
  parameter int W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_valid,
  input  logic [IDX_W-1:0] bit_idx,
  input  logic             cs_bit,
  output logic [W-1:0]     win
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic hit;
    assign hit = frame_valid & (bit_idx == IDX_W'(BASE + i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   win[i] <= 1'b0;
      else if (hit) win[i] <= cs_bit;
    end
  end

endmodule

// File: rtl/cs_crc_serial.sv
module cs_crc_serial #(
  parameter int                 FRAMES = 192,
  parameter int                 CRC_W  = 8,
  parameter logic [CRC_W-1:0]   POLY   = 8'h1D,
  parameter logic [CRC_W-1:0]   INIT   = 8'hFF,
  localparam int                IDX_W  = $clog2(FRAMES + 2),
  localparam int                DATA_N = FRAMES - CRC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_valid,
  input  logic             frame_first,
  input  logic [IDX_W-1:0] bit_idx,
  input  logic             cs_bit,
  output logic [CRC_W-1:0] crc_val
);

  logic [CRC_W-1:0] crc_q, crc_d, base;
  logic             fb, in_data;

  assign in_data = bit_idx < IDX_W'(DATA_N);
  assign base    = frame_first ? INIT : crc_q;
  assign fb      = base[CRC_W-1] ^ cs_bit;

  always_comb begin
    crc_d = crc_q;
    if (frame_valid && in_data)
      crc_d = {base[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= INIT;
    else        crc_q <= crc_d;
  end

  assign crc_val = crc_q;

endmodule

// File: rtl/cs_field_decode.sv
module cs_field_decode
  import cs_dec_pkg::*;
(
  input  logic [CS_B0_W-1:0] b0,
  input  logic [CS_B1_W-1:0] b1,
  input  logic               crc_ok,
  output cs_status_t         status
);

  logic [6:0] cat;
  logic       gen, rev, ign;
  logic [1:0] emph;

  assign cat = b1[6:0];
  assign gen = b1[7];

  // code written bit 0 first: 001xxxx, 0111xxx, 100xxxx
  assign rev = (cat[2:0] == 3'b100) | (cat[3:0] == 4'b1110) | (cat[2:0] == 3'b001);
  assign ign = (cat == 7'b0000000) | (cat == 7'b0000110);

  always_comb begin
    unique case (b0[4:2])
      3'b000:  emph = 2'b11;
      3'b001:  emph = 2'b10;
      3'b011:  emph = 2'b01;
      3'b111:  emph = 2'b00;
      default: emph = 2'b11;
    endcase
  end

  always_comb begin
    status.consumer       = ~b0[0];
    status.flags[FLG_DATA] = b0[1];
    if (~b0[0]) begin
      status.flags[FLG_LO]  = ~b0[2];
      status.flags[FLG_HI]  = ~b0[3];
      status.flags[FLG_GEN] = rev ? gen : ~gen;
      status.flags[FLG_CAT] = ~ign;
    end else begin
      status.flags[FLG_HI]  = emph[1];
      status.flags[FLG_LO]  = emph[0];
      status.flags[FLG_GEN] = ~b1[1];
      status.flags[FLG_CAT] = crc_ok;
    end
  end

endmodule

// File: rtl/cs_block_decoder.sv
module cs_block_decoder
  import cs_dec_pkg::*;
#(
  parameter int               FRAMES    = CS_FRAMES,
  parameter int               CRC_W     = CS_CRC_W,
  parameter logic [CRC_W-1:0] CRC_POLY  = CS_CRC_POLY,
  parameter logic [CRC_W-1:0] CRC_INIT  = CS_CRC_INIT
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frame_valid,
  input  logic                 frame_first,
  input  logic                 cs_bit,
  output logic                 consumer_mode,
  output logic [CS_FLAG_W-1:0] status_flags,
  output logic                 block_strobe
);

  localparam int IDX_W = $clog2(FRAMES + 2);

  logic [IDX_W-1:0]   bit_idx;
  logic               commit;
  logic [CS_B0_W-1:0] b0;
  logic [CS_B1_W-1:0] b1;
  logic [CRC_W-1:0]   crc_rx, crc_calc;
  logic               crc_ok;
  cs_status_t         dec, stat_q, stat_d;
  logic               stb_q, stb_d;

  cs_frame_counter #(.FRAMES(FRAMES)) u_cnt (
    .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .frame_first(frame_first),
    .bit_idx(bit_idx), .commit(commit)
  );

  cs_bit_window #(.IDX_W(IDX_W), .BASE(CS_B0_BASE), .W(CS_B0_W)) u_b0 (
    .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .bit_idx(bit_idx),
    .cs_bit(cs_bit), .win(b0)
  );

  cs_bit_window #(.IDX_W(IDX_W), .BASE(CS_B1_BASE), .W(CS_B1_W)) u_b1 (
    .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .bit_idx(bit_idx),
    .cs_bit(cs_bit), .win(b1)
  );

  cs_bit_window #(.IDX_W(IDX_W), .BASE(FRAMES - CRC_W), .W(CRC_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .bit_idx(bit_idx),
    .cs_bit(cs_bit), .win(crc_rx)
  );

  cs_crc_serial #(.FRAMES(FRAMES), .CRC_W(CRC_W), .POLY(CRC_POLY), .INIT(CRC_INIT)) u_crc (
    .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .frame_first(frame_first),
    .bit_idx(bit_idx), .cs_bit(cs_bit), .crc_val(crc_calc)
  );

  assign crc_ok = (crc_calc == crc_rx);

  cs_field_decode u_dec (
    .b0(b0), .b1(b1), .crc_ok(crc_ok), .status(dec)
  );

  always_comb begin
    stat_d = stat_q;
    if (commit) stat_d = dec;
    stb_d = commit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= CS_STATUS_RST;
      stb_q  <= 1'b0;
    end else begin
      stat_q <= stat_d;
      stb_q  <= stb_d;
    end
  end

  assign consumer_mode = stat_q.consumer;
  assign status_flags  = stat_q.flags;
  assign block_strobe  = stb_q;

endmodule

// File: rtl/cs_block_decoder_chk.sv
module cs_block_decoder_chk #(
  parameter int FRAMES = 192,
  parameter int FLAG_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_valid,
  input logic              frame_first,
  input logic              consumer_mode,
  input logic [FLAG_W-1:0] status_flags,
  input logic              block_strobe
);

  localparam int IDX_W = $clog2(FRAMES + 2);
  localparam logic [IDX_W-1:0] OVER = IDX_W'(FRAMES + 1);

  logic [IDX_W-1:0] len_q, len_d, last_q, last_d;

  always_comb begin
    len_d  = len_q;
    last_d = last_q;
    if (frame_valid) begin
      if (frame_first) begin
        last_d = len_q;
        len_d  = IDX_W'(1);
      end else if (len_q != OVER) begin
        len_d = len_q + IDX_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q  <= '0;
      last_q <= '0;
    end else begin
      len_q  <= len_d;
      last_q <= last_d;
    end
  end

  // R2
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    block_strobe |=> !block_strobe);

  // R2
  status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !block_strobe |-> $stable({consumer_mode, status_flags}));

  // R3
  strobe_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    block_strobe |-> (last_q == IDX_W'(FRAMES)));

  // R2
  strobe_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(frame_valid && frame_first) && (last_q == IDX_W'(FRAMES))) |-> block_strobe);

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(frame_valid) |-> !block_strobe);

endmodule

bind cs_block_decoder cs_block_decoder_chk #(.FRAMES(FRAMES), .FLAG_W(cs_dec_pkg::CS_FLAG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .frame_first(frame_first),
  .consumer_mode(consumer_mode), .status_flags(status_flags), .block_strobe(block_strobe)
);

// File: tb/tb_cs_block_decoder.sv
module tb_cs_block_decoder;

  localparam int FRAMES = 192;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       frame_valid, frame_first, cs_bit;
  logic       consumer_mode, block_strobe;
  logic [4:0] status_flags;

  always #10 clk = ~clk;

  cs_block_decoder dut (
    .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .frame_first(frame_first),
    .cs_bit(cs_bit), .consumer_mode(consumer_mode), .status_flags(status_flags),
    .block_strobe(block_strobe)
  );

  int   n_chk = 0, n_fail = 0;
  int   stb_seen = 0, stb_exp = 0;
  bit   cmp_en = 0, done = 0;
  logic mq[$];
  logic       exp_cons = 1'b1, exp_stb = 1'b0;
  logic [4:0] exp_flags = 5'b01110;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic int crc_bits(input logic [191:0] v);
    int c = 255;
    for (int i = 0; i < FRAMES - 8; i++) begin
      int top = (c >> 7) & 1;
      c = (c << 1) & 255;
      if ((top ^ int'(v[i])) != 0) c = c ^ 29;
    end
    return c;
  endfunction

  function automatic void model_decode();
    int cat = 0, c = 255, rx = 0;
    logic gen;
    bit rev;
    for (int i = 0; i < 7; i++) cat |= int'(mq[8 + i]) << i;
    gen = mq[15];
    exp_cons     = !mq[0];
    exp_flags[0] = mq[1];
    if (exp_cons) begin
      exp_flags[1] = !mq[2];
      exp_flags[2] = !mq[3];
      rev = ((cat & 7) == 4) || ((cat & 15) == 14) || ((cat & 7) == 1);
      exp_flags[3] = rev ? gen : !gen;
      exp_flags[4] = !(cat == 0 || cat == 6);
    end else begin
      if (!mq[2] && !mq[3] && !mq[4])     exp_flags[2:1] = 2'b11;
      else if (mq[2] && !mq[3] && !mq[4]) exp_flags[2:1] = 2'b10;
      else if (mq[2] && mq[3] && !mq[4])  exp_flags[2:1] = 2'b01;
      else if (mq[2] && mq[3] && mq[4])   exp_flags[2:1] = 2'b00;
      else                                exp_flags[2:1] = 2'b11;
      exp_flags[3] = !mq[9];
      for (int i = 0; i < FRAMES - 8; i++) begin
        int top = (c >> 7) & 1;
        c = (c << 1) & 255;
        if ((top ^ int'(mq[i])) != 0) c = c ^ 29;
      end
      for (int k = 0; k < 8; k++) rx |= int'(mq[FRAMES - 8 + k]) << k;
      exp_flags[4] = (c == rx);
    end
  endfunction

  function automatic void model_step(input logic b, input logic first);
    exp_stb = 1'b0;
    if (first) begin
      if (mq.size() == FRAMES) begin
        model_decode();
        exp_stb = 1'b1;
        stb_exp++;
      end
      mq.delete();
    end
    mq.push_back(b);
  endfunction

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      frame_valid = 1'b0;
      frame_first = 1'b0;
      @(posedge clk);
      exp_stb = 1'b0;
    end
  endtask

  task automatic frame(input logic b, input logic first, input int gap);
    @(negedge clk);
    frame_valid = 1'b1;
    frame_first = first;
    cs_bit      = b;
    @(posedge clk);
    model_step(b, first);
    if (gap > 0) idle(gap);
  endtask

  function automatic logic [191:0] mk(input logic [7:0] b0, input logic [7:0] b1, input bit good);
    logic [191:0] v;
    int c;
    v[7:0]  = b0;
    v[15:8] = b1;
    for (int i = 16; i < FRAMES - 8; i++) v[i] = 1'($urandom % 2);
    c = crc_bits(v);
    v[191:184] = good ? 8'(c) : 8'(c ^ 1);
    return v;
  endfunction

  task automatic send_block(input logic [191:0] v, input int gap);
    for (int i = 0; i < FRAMES; i++) frame(v[i], i == 0, gap);
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (cmp_en && !done) begin
      if (block_strobe) stb_seen++;
      check(block_strobe == exp_stb, "R2", "block_strobe", int'(block_strobe), int'(exp_stb));
      check(consumer_mode == exp_cons, "R4", "consumer_mode", int'(consumer_mode), int'(exp_cons));
      check(status_flags[0] == exp_flags[0], "R5", "flag0", int'(status_flags[0]), int'(exp_flags[0]));
      check(status_flags[2:1] == exp_flags[2:1], exp_cons ? "R6" : "R9", "flags2:1",
            int'(status_flags[2:1]), int'(exp_flags[2:1]));
      check(status_flags[3] == exp_flags[3], exp_cons ? "R7" : "R10", "flag3",
            int'(status_flags[3]), int'(exp_flags[3]));
      check(status_flags[4] == exp_flags[4], exp_cons ? "R8" : "R11", "flag4",
            int'(status_flags[4]), int'(exp_flags[4]));
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  logic [7:0] cb0 [16] = '{8'h0E, 8'h00, 8'h02, 8'h00, 8'h08, 8'h00, 8'h04, 8'h00,
                           8'h0A, 8'h00, 8'h06, 8'h00, 8'h0C, 8'hE0, 8'h02, 8'h00};
  logic [7:0] cb1 [16] = '{8'h80, 8'h04, 8'h84, 8'h0E, 8'h8E, 8'h01, 8'h81, 8'h06,
                           8'h86, 8'h02, 8'h46, 8'h08, 8'h88, 8'h00, 8'h0C, 8'h8C};
  logic [7:0] pb0 [9]  = '{8'h01, 8'h05, 8'h0D, 8'h1D, 8'h09, 8'h05, 8'h03, 8'hE1, 8'h11};
  logic [7:0] pb1 [9]  = '{8'h00, 8'h02, 8'h00, 8'h02, 8'h00, 8'h00, 8'h02, 8'hFF, 8'h00};
  bit         pgood[9] = '{1, 1, 1, 1, 1, 0, 1, 1, 0};

  initial begin
    int s0;
    logic       sv_cons;
    logic [4:0] sv_flags;
    rst_n = 1'b0;
    frame_valid = 1'b0;
    frame_first = 1'b0;
    cs_bit = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(consumer_mode == 1'b1, "R1", "consumer_mode", int'(consumer_mode), 1);
    check(status_flags == 5'b01110, "R1", "status_flags", int'(status_flags), 14);
    check(block_strobe == 1'b0, "R1", "block_strobe", int'(block_strobe), 0);
    cmp_en = 1;

    // first flag with no block behind it: no strobe (R3)
    send_block(mk(8'h00, 8'h00, 1), 0);
    check(stb_seen == 0, "R3", "strobes before first full block", stb_seen, 0);

    for (int i = 0; i < 16; i++) send_block(mk(cb0[i], cb1[i], 1), 0);
    for (int i = 0; i < 9; i++)  send_block(mk(pb0[i], pb1[i], pgood[i]), 0);

    // short block discarded (R3)
    send_block(mk(8'h0E, 8'h80, 1), 0);
    for (int i = 0; i < 100; i++) frame(1'b1, i == 0, 0);
    idle(2);
    s0 = stb_seen;
    sv_cons = consumer_mode;
    sv_flags = status_flags;
    send_block(mk(8'h01, 8'h02, 1), 0);
    idle(2);
    check(stb_seen == s0, "R3", "strobe after short block", stb_seen, s0);
    check(consumer_mode == sv_cons, "R3", "mode after short block", int'(consumer_mode), int'(sv_cons));
    check(status_flags == sv_flags, "R3", "flags after short block", int'(status_flags), int'(sv_flags));

    // over-long block discarded (R3)
    send_block(mk(8'h00, 8'h06, 1), 0);
    for (int i = 0; i < 9; i++) frame(1'b1, 1'b0, 0);
    s0 = stb_seen;
    sv_flags = status_flags;
    send_block(mk(8'h03, 8'h00, 1), 0);
    idle(2);
    check(stb_seen == s0, "R3", "strobe after long block", stb_seen, s0);
    check(status_flags == sv_flags, "R3", "flags after long block", int'(status_flags), int'(sv_flags));

    // idle gaps between frames (R12)
    send_block(mk(8'h0E, 8'h84, 1), 0);
    s0 = stb_seen;
    send_block(mk(8'h05, 8'h00, 1), 1);
    send_block(mk(8'h00, 8'h01, 1), 0);
    frame(1'b0, 1'b1, 0);
    idle(3);
    check(stb_seen == s0 + 3, "R12", "strobes with idle gaps", stb_seen, s0 + 3);

    check(stb_seen == stb_exp, "R2", "total strobes", stb_seen, stb_exp);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule